// File: doc/BRIEF.md
# Qualified Change-of-State Detector

This block watches a bank of general-purpose pins and reports a change on a pin only after its new level has held steady for one to two periods of a slow sample tick. The tick is about 38.4 kHz, so the hold time is roughly 25 to 50 µs. Each pin first passes through a two-flop synchroniser. The pin is then sampled on an external enable tick. A pin's qualified level moves only when two successive tick samples agree on a value that differs from the current qualified level.

Each qualified change sets a sticky per-pin flag. Software clears a flag by writing a one to its bit. A per-pin enable gates the flags into a single interrupt line. An 8-bit counter records the qualified changes on pin 0. The block has no notion of pin direction. Pins that the chip itself drives are observed exactly like inputs, so toggles of the chip's own handshake outputs can be counted.

Top module: `cos_detect`

## Requirements
- R1: After reset, `level_q`, `chg_flag` and `pin0_count` are all zero and `irq` is low.
- R2: A pin's bit in `level_q` changes only at a clock edge where `tick` is high. At that edge, the synchronised pin value and the value captured at the previous tick must be equal, and must differ from the bit's current value. A steady new level is therefore taken on the second tick after it reaches the synchroniser output.
- R3: A pulse that is seen by at most one tick sample leaves `level_q`, `chg_flag` and `pin0_count` unchanged.
- R4: A qualified change on pin n sets `chg_flag[n]`. The flag stays set until it is cleared, and further changes do not clear it.
- R5: A clock edge with `clr_wr` high clears each `chg_flag` bit whose `clr_mask` bit is 1, and leaves the other bits unchanged. If a qualified change on a pin occurs at the same edge as a clear of that pin's flag, the flag stays set.
- R6: `irq` is high exactly when some pin has both its `chg_flag` bit and its `int_en` bit at 1. Changing `int_en` takes effect without a clock edge.
- R7: `pin0_count` increments by one on every qualified change of pin 0, on both rising and falling edges. It wraps from 255 to 0.
- R8: Pins qualify independently. Changes on several pins that are taken at the same tick all update at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample enable, about 38.4 kHz |
| gpio_in | input | 14 | Asynchronous pin levels |
| clr_wr | input | 1 | Write strobe for flag clear |
| clr_mask | input | 14 | Flags to clear, 1 = clear |
| int_en | input | 14 | Per-pin interrupt enable |
| level_q | output | 14 | Qualified pin levels |
| chg_flag | output | 14 | Sticky change flags |
| irq | output | 1 | Combined interrupt |
| pin0_count | output | 8 | Qualified change count of pin 0 |

## Verification
A pin level applied on a falling edge reaches the synchroniser output after two rising edges. It is captured at the first tick edge after that and qualified at the second tick edge. `level_q`, `chg_flag` and `pin0_count` all change at that second tick edge, and `irq` follows in the same cycle. The bench waits three cycles after driving a pin before it issues each one-cycle tick. It reads every output at the falling edge that follows the edge where the result is due. A clear written together with the qualifying tick is checked at that same falling edge.

// File: rtl/cos_detect.sv
module cos_detect #(
  parameter int NPIN = 14,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NPIN-1:0] gpio_in,
  input  logic            clr_wr,
  input  logic [NPIN-1:0] clr_mask,
  input  logic [NPIN-1:0] int_en,
  output logic [NPIN-1:0] level_q,
  output logic [NPIN-1:0] chg_flag,
  output logic            irq,
  output logic [CNTW-1:0] pin0_count
);

  logic [NPIN-1:0] sync1, sync2, samp;
  logic [NPIN-1:0] qual_chg;
  logic [NPIN-1:0] clr_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= gpio_in;
      sync2 <= sync1;
    end
  end

  assign qual_chg = tick ? ((sync2 ^ level_q) & ~(sync2 ^ samp)) : '0;
  assign clr_bits = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp       <= '0;
      level_q    <= '0;
      chg_flag   <= '0;
      pin0_count <= '0;
    end else begin
      if (tick) samp <= sync2;
      level_q  <= level_q ^ qual_chg;
      chg_flag <= (chg_flag & ~clr_bits) | qual_chg;
      if (qual_chg[0]) pin0_count <= pin0_count + 1'b1;
    end
  end

  assign irq = |(chg_flag & int_en);

  p_level_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level_q));

  p_two_samples_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (sync2 != samp) && ((sync2 ^ samp) == (sync2 ^ level_q)) && (sync2 != level_q))
      |=> $stable(level_q));

  p_flag_follows_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> (((level_q ^ $past(level_q)) & ~chg_flag) == '0));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(chg_flag) & ~chg_flag) == '0));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q[0] != $past(level_q[0])) |-> (pin0_count == CNTW'($past(pin0_count) + 1'b1)));

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q[0] == $past(level_q[0])) |-> $stable(pin0_count));

endmodule

// File: tb/cos_detect_test.sv
module cos_detect_test;
  localparam int NPIN = 14;

  logic clk = 0, rst_n = 0, tick = 0, clr_wr = 0;
  logic [NPIN-1:0] gpio_in = '0, clr_mask = '0, int_en = '0;
  logic [NPIN-1:0] level_q, chg_flag;
  logic irq;
  logic [7:0] pin0_count;

  int n_chk = 0, n_fail = 0;
  logic [7:0] cnt_exp = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cos_detect uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gpio_in(gpio_in),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .int_en(int_en),
    .level_q(level_q), .chg_flag(chg_flag), .irq(irq), .pin0_count(pin0_count)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic apply(logic [NPIN-1:0] v);
    gpio_in = v;
    settle();
    do_tick();
    do_tick();
  endtask

  task automatic clear(logic [NPIN-1:0] m);
    @(negedge clk) begin clr_wr = 1; clr_mask = m; end
    @(negedge clk) begin clr_wr = 0; clr_mask = '0; end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 level", level_q, 0);
    check("R1 flag", chg_flag, 0);
    check("R1 count", pin0_count, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_qualify();
    gpio_in = 14'h0004;
    settle();
    do_tick();
    check("R2 first tick no update", level_q, 0);
    do_tick();
    check("R2 second tick update", level_q, 14'h0004);
    check("R4 flag set", chg_flag, 14'h0004);
    apply(14'h0000);
    check("R4 flag sticky after return", chg_flag, 14'h0004);
    check("R2 return level", level_q, 0);
    clear(14'h0004);
  endtask

  task automatic t_glitch();
    gpio_in = 14'h0010;
    settle();
    do_tick();
    gpio_in = 14'h0000;
    settle();
    do_tick();
    do_tick();
    check("R3 glitch level", level_q, 0);
    check("R3 glitch flag", chg_flag, 0);
    gpio_in = 14'h0001;
    repeat (2) @(negedge clk);
    gpio_in = 14'h0000;
    settle();
    do_tick();
    do_tick();
    check("R3 short pulse count", pin0_count, cnt_exp);
    check("R3 short pulse flag", chg_flag, 0);
  endtask

  task automatic t_clear();
    apply(14'h0022);
    check("R8 two pins same tick", level_q, 14'h0022);
    check("R8 two flags", chg_flag, 14'h0022);
    clear(14'h0020);
    check("R5 masked clear", chg_flag, 14'h0002);
    gpio_in = 14'h0020;
    settle();
    do_tick();
    @(negedge clk) begin tick = 1; clr_wr = 1; clr_mask = 14'h0002; end
    @(negedge clk) begin tick = 0; clr_wr = 0; clr_mask = '0; end
    check("R5 change wins over clear", chg_flag, 14'h0002);
    clear(14'h3fff);
    check("R5 full clear", chg_flag, 0);
    apply(14'h0000);
    clear(14'h3fff);
  endtask

  task automatic t_irq();
    int_en = 14'h0100;
    apply(14'h0200);
    check("R6 disabled pin no irq", irq, 0);
    #1 int_en = 14'h0300;
    #1 check("R6 enable raises irq", irq, 1);
    int_en = 14'h0000;
    #1 check("R6 mask drops irq", irq, 0);
    int_en = 14'h0200;
    clear(14'h0200);
    check("R6 clear drops irq", irq, 0);
    apply(14'h0000);
    clear(14'h3fff);
    int_en = '0;
  endtask

  task automatic t_count();
    for (int i = 0; i < 256; i++) begin
      apply({13'd0, ~level_q[0]});
      cnt_exp++;
      if (i == 254) check("R7 count at 255", pin0_count, 8'd255);
    end
    check("R7 count wrapped", pin0_count, cnt_exp);
    check("R7 count value 0", pin0_count, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_qualify();
    t_glitch();
    t_clear();
    t_irq();
    t_count();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule